// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

A memory-mapped system timer built around a single free-running up-counter shared by several independent compare channels. The counter advances once per prescaled tick. A control word turns counting on and off, sets the prescale divider (the field holds the divide value minus one) and chooses whether an external debug-halt input freezes counting. Software can read the counter at any time and can load it with a new value.

Each channel holds a compare value and an enable. On the tick that moves the counter onto a channel's compare value, an enabled channel sets its flag. The flag drives that channel's own interrupt line through the enable. Software clears a flag by writing a one to its bit. A simple register bus carries the accesses. It has an address, write data, a write strobe and a read strobe, and read data is registered one cycle after the read strobe.

Top module: `cmp_timer`

## Requirements
- R1: The counter adds one on every prescaled tick and wraps from all ones to zero.
- R2: With the prescale field (control bits 15:8) at value N, the counter advances once every N+1 clock cycles, for N from 0 to 255.
- R3: Control bit 0 enables counting. While it is clear, the counter holds its value and the prescaler restarts from zero.
- R4: When control bit 1 is set and `dbg_halt_i` is high, the counter and prescaler hold. With bit 1 clear, `dbg_halt_i` has no effect.
- R5: The counter register at offset 0x04 reads back the current count. A write loads the written value, and that load takes priority over a tick in the same cycle.
- R6: Channel n occupies offsets 0x10+16n (control, bit 0 is the enable), +0x4 (flag in bit 0) and +0x8 (compare). An enabled channel sets its flag on the tick that moves the counter to a value equal to its compare register.
- R7: A channel whose enable bit is zero raises no new flag.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: If a flag-clear write and a match fall in the same cycle, the flag stays set.
- R10: Each channel has its own interrupt output, equal to its flag ANDed with its enable. Clearing the enable masks the line but keeps the flag.
- R11: Reset clears the control word, the counter, all channel registers and all flags. Read data appears one cycle after `re_i`, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address of the register |
| wdata_i | input | CNT_W (32) | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | CNT_W (32) | Read data, valid the cycle after `re_i` |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | N_CHAN (4) | Per-channel interrupt lines |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels and an 8-bit prescale field. Loading the counter just below all ones brings the wrap and a compare value of zero within a few cycles. The widest divider is covered by running 511 cycles at a prescale of 255. With four channels the bench can hold one channel matching, one never matching and one disabled at its compare value, all in the same run.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned REG_CTRL  = 'h00;
  localparam int unsigned REG_CNT   = 'h04;
  localparam int unsigned CH_SHIFT  = 4;   // 16-byte channel groups
  localparam int unsigned CH_FIRST  = 1;   // group index of channel 0
  localparam int unsigned PSC_LSB   = 8;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_FRZ   = 1;

  typedef enum logic [1:0] {
    CH_CTRL = 2'd0,
    CH_FLAG = 2'd1,
    CH_CMP  = 2'd2,
    CH_NONE = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/cmp_timer_psc.sv
module cmp_timer_psc #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic             wrap;

  // >= keeps the period bounded if the divider is lowered mid-count
  assign wrap   = (psc_q >= div_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!en_i)  psc_q <= '0;
    else if (run_i)  psc_q <= wrap ? '0 : psc_q + PSC_W'(1);
  end

  AST_PSC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> psc_q == '0);  // R3
  AST_PSC_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !run_i |=> $stable(psc_q));  // R4
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_flag_i,
  input  logic             wr_cmp_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic             en_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  logic             en_q, flag_q, match;
  logic [CNT_W-1:0] cmp_q;

  assign match = en_q && adv_i && (cnt_next_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl_i) en_q  <= wdata_i[0];
      if (wr_cmp_i)  cmp_q <= wdata_i;
      if (match)                       flag_q <= 1'b1;  // match beats clear
      else if (wr_flag_i && wdata_i[0]) flag_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign cmp_o  = cmp_q;
  assign irq_o  = flag_q & en_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag_q);  // R9
  AST_NO_FLAG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !flag_q |=> !flag_q);  // R7
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag_i && wdata_i[0] && !match |=> !flag_q);  // R8
  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !(wr_flag_i && wdata_i[0]) |=> flag_q);  // R8
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              dbg_halt_i,
  output logic [N_CHAN-1:0] irq_o
);
  localparam int unsigned GRP_W = ADDR_W - CH_SHIFT;

  logic              ctrl_en_q, ctrl_frz_q;
  logic [PSC_W-1:0]  ctrl_psc_q;
  logic [CNT_W-1:0]  cnt_q, cnt_next, rd_val;
  logic              ctrl_wr, cnt_wr, run, tick, adv;
  logic              aligned;
  ch_sel_e           sel;

  logic [N_CHAN-1:0] ch_hit, ch_en, ch_flag;
  logic [CNT_W-1:0]  ch_cmp [N_CHAN];

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = ch_sel_e'(addr_i[3:2]);
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(REG_CTRL));
  assign cnt_wr  = we_i && (addr_i == ADDR_W'(REG_CNT));

  // control word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_frz_q <= 1'b0;
      ctrl_psc_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_en_q  <= wdata_i[BIT_EN];
      ctrl_frz_q <= wdata_i[BIT_FRZ];
      ctrl_psc_q <= wdata_i[PSC_LSB +: PSC_W];
    end
  end

  assign run = ctrl_en_q && !(ctrl_frz_q && dbg_halt_i);

  cmp_timer_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_en_q),
    .run_i  (run),
    .div_i  (ctrl_psc_q),
    .tick_o (tick)
  );

  // counter: a bus load wins over a tick
  assign cnt_next = cnt_q + CNT_W'(1);
  assign adv      = tick && !cnt_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wdata_i;
    else if (tick)    cnt_q <= cnt_next;
  end

  for (genvar n = 0; n < N_CHAN; n++) begin : g_ch
    logic hit;
    assign hit = aligned && (addr_i[ADDR_W-1:CH_SHIFT] == GRP_W'(n + CH_FIRST));
    assign ch_hit[n] = hit;

    cmp_timer_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_ctrl_i  (we_i && hit && sel == CH_CTRL),
      .wr_flag_i  (we_i && hit && sel == CH_FLAG),
      .wr_cmp_i   (we_i && hit && sel == CH_CMP),
      .wdata_i    (wdata_i),
      .adv_i      (adv),
      .cnt_next_i (cnt_next),
      .en_o       (ch_en[n]),
      .flag_o     (ch_flag[n]),
      .cmp_o      (ch_cmp[n]),
      .irq_o      (irq_o[n])
    );
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(REG_CTRL)) begin
      rd_val[BIT_EN]            = ctrl_en_q;
      rd_val[BIT_FRZ]           = ctrl_frz_q;
      rd_val[PSC_LSB +: PSC_W]  = ctrl_psc_q;
    end else if (addr_i == ADDR_W'(REG_CNT)) begin
      rd_val = cnt_q;
    end
    for (int n = 0; n < N_CHAN; n++) begin
      if (ch_hit[n]) begin
        case (sel)
          CH_CTRL: rd_val[0] = ch_en[n];
          CH_FLAG: rd_val[0] = ch_flag[n];
          CH_CMP:  rd_val    = ch_cmp[n];
          default: rd_val    = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (re_i)  rdata_o <= rd_val;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cnt_wr |=> cnt_q == $past(cnt_q) + CNT_W'(1));  // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_q && !cnt_wr |=> $stable(cnt_q));  // R3
  AST_CNT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_frz_q && dbg_halt_i && !cnt_wr |=> $stable(cnt_q));  // R4
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_q == $past(wdata_i));  // R5
  AST_ONE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_hit));  // R6
endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, halt = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        re_d = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  cmp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .dbg_halt_i(halt), .irq_o(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04;
  function automatic logic [7:0] ch_a(int n, int off);
    return 8'(8'h10 + 16 * n + off);
  endfunction

  always @(posedge clk) re_d <= re;

  // monitor: compare registered read data against queued expectations
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    addr = a; re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", t, irq, e);
    end
  endtask

  // run with control word c for d edges, counting the enable edge's successor
  task automatic run_for(input logic [31:0] c, input int d);
    wr(A_CTRL, c);
    repeat (d - 1) @(negedge clk);
    wr(A_CTRL, c & ~32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(A_CTRL, 32'h0, "R11 ctrl reset");
    rd(A_CNT, 32'h0, "R11 cnt reset");
    rd(ch_a(0, 4), 32'h0, "R11 flag0 reset");
    rd(ch_a(3, 8), 32'h0, "R11 cmp3 reset");
    chk_irq(4'b0000, "R11 irq reset");
    rd(8'h0C, 32'h0, "R11 unmapped read");

    // R5 load and read back
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, 32'h0000_1234, "R5 cnt load");
    wr(A_CTRL, 32'h0000_0500);
    rd(A_CTRL, 32'h0000_0500, "R2 ctrl readback");

    // R1/R3 divide by one, then hold
    wr(A_CNT, 32'h0);
    run_for(32'h1, 10);
    rd(A_CNT, 32'd10, "R1 count psc0");
    repeat (5) @(negedge clk);
    rd(A_CNT, 32'd10, "R3 hold when disabled");

    // R2 prescale
    wr(A_CNT, 32'h0);
    run_for(32'h0000_0301, 13);
    rd(A_CNT, 32'd3, "R2 psc3");
    wr(A_CNT, 32'h0);
    run_for(32'h0000_FF01, 511);
    rd(A_CNT, 32'd1, "R2 psc255");

    // R4 debug freeze
    wr(A_CNT, 32'd100);
    halt = 1'b1;
    run_for(32'h3, 10);
    rd(A_CNT, 32'd100, "R4 frozen");
    run_for(32'h1, 10);
    rd(A_CNT, 32'd110, "R4 halt ignored without freeze bit");
    halt = 1'b0;

    // R6/R7/R10 matches
    wr(ch_a(0, 8), 32'd5);    wr(ch_a(0, 0), 32'h1);
    wr(ch_a(1, 8), 32'd1000); wr(ch_a(1, 0), 32'h1);
    wr(ch_a(2, 8), 32'd3);    wr(ch_a(2, 0), 32'h0);
    wr(A_CNT, 32'h0);
    run_for(32'h1, 10);
    rd(ch_a(0, 4), 32'h1, "R6 flag0 set on match");
    rd(ch_a(1, 4), 32'h0, "R6 flag1 no match");
    rd(ch_a(2, 4), 32'h0, "R7 disabled channel no flag");
    chk_irq(4'b0001, "R10 irq0 only");

    // R8 write-one-to-clear
    wr(ch_a(0, 4), 32'h0);
    rd(ch_a(0, 4), 32'h1, "R8 write zero keeps flag");
    wr(ch_a(0, 4), 32'h1);
    rd(ch_a(0, 4), 32'h0, "R8 write one clears");
    chk_irq(4'b0000, "R8 irq after clear");

    // R10 masking
    wr(A_CNT, 32'h0);
    run_for(32'h1, 10);
    wr(ch_a(0, 0), 32'h0);
    chk_irq(4'b0000, "R10 irq masked by enable");
    rd(ch_a(0, 4), 32'h1, "R10 flag kept while masked");
    wr(ch_a(0, 0), 32'h1);
    chk_irq(4'b0001, "R10 irq unmasked");
    wr(ch_a(0, 4), 32'h1);

    // R1 wrap, compare at zero
    wr(ch_a(1, 8), 32'h0);
    wr(A_CNT, 32'hFFFF_FFFE);
    run_for(32'h1, 4);
    rd(A_CNT, 32'd2, "R1 wrap");
    rd(ch_a(1, 4), 32'h1, "R1 match at zero after wrap");
    chk_irq(4'b0010, "R10 irq1 separate line");
    wr(ch_a(1, 4), 32'h1);

    // R9 clear collides with match
    wr(ch_a(0, 8), 32'd4);
    wr(A_CNT, 32'h0);
    run_for(32'h1, 7);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(ch_a(0, 4), 32'h1);    // lands on the edge moving 3 -> 4
    wr(A_CTRL, 32'h0);
    rd(ch_a(0, 4), 32'h1, "R9 match wins over clear");
    rd(A_CNT, 32'd5, "R9 count at collision");
    wr(ch_a(0, 4), 32'h1);
    rd(ch_a(0, 4), 32'h0, "R8 clear after collision");

    // R5 load beats tick
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h1);
    wr(A_CNT, 32'd50);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd51, "R5 write beats tick");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule